// File: doc/BRIEF.md
# Prioritized interrupt level selector

This block turns a vector of interrupt level requests into a pending trap type for the processor core. Each cycle it finds the highest requested level from 15 down to 1 and forms an external-interrupt trap type by ORing that level into the low four bits of a class code. It keeps one pending-trap register, which it shares with the trap sequencer. The sequencer can load a synchronous (non-interrupt) trap into it, and it clears the register with a strobe once the trap has been taken.

A new interrupt selection may only take the pending slot when the slot is empty or already holds an external interrupt. A synchronous trap that is waiting is never displaced. When the chosen trap type changes, the block raises a hard-interrupt request line to the core and gives a one-cycle change pulse. When every request goes away while an external interrupt is pending, the slot empties and the request line drops. All outputs are registered, so each takes effect one clock after the inputs that cause it.

Top module: `irqsel_top`

## Requirements
- R1: While `rst` is high at a clock edge, `pend_type_o` becomes 0 and `hard_req_o` and `chg_o` become low.
- R2: For each requested level, the selected trap type is `EXT_BASE | level`, where the level is the highest set bit of `lvl_req_i` among bits 15 to 1. The default `EXT_BASE` is 0x10, so level 15 gives 0x1F.
- R3: Bit 0 of `lvl_req_i` is never selected. A vector with only bit 0 set leaves the pending type, the request line and the pulse as they were.
- R4: An interrupt selection is written only when the pending type is 0 or its upper bits [7:4] equal those of `EXT_BASE`.
- R5: While a non-zero pending type of another class is held, requests leave `pend_type_o` and `hard_req_o` unchanged and give no pulse.
- R6: `hard_req_o` is set and `chg_o` pulses high for exactly one cycle only when the newly selected type differs from the pending one. Reselecting the same type gives no pulse.
- R7: An all-zero `lvl_req_i` while an external-interrupt class type is pending clears the pending type to 0 and drops `hard_req_o` on the next edge.
- R8: `take_clr_i` zeroes the pending type and drops `hard_req_o`. It takes priority over every input except reset.
- R9: `sync_ld_i` writes `sync_type_i` into the pending slot and leaves `hard_req_o` unchanged. It takes priority over interrupt selection and yields only to `take_clr_i` and reset.
- R10: An all-zero `lvl_req_i` while the pending type is 0 or of another class changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_req_i | input | 16 | Interrupt level requests, bit n = level n |
| take_clr_i | input | 1 | Strobe from the sequencer: the trap has been taken |
| sync_ld_i | input | 1 | Load a synchronous trap into the pending slot |
| sync_type_i | input | 8 | Trap type to load |
| pend_type_o | output | 8 | Pending trap type |
| hard_req_o | output | 1 | Hard-interrupt request to the core |
| chg_o | output | 1 | One-cycle pulse on a new interrupt selection |

## Verification
Two functions can fall in the same cycle. The sequencer's clear or synchronous load can arrive together with a new interrupt level, and an all-zero request vector can arrive in the same cycle as an external interrupt pending in the slot. The random phase drives the clear and load strobes at random on top of level vectors that are biased toward empty, bit-0-only and single-bit patterns, so these cycles occur often. The directed cases set each collision up on purpose. Each cycle is judged against a bench model that applies reset, then clear, then load, then selection, and compares all three outputs one edge later.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
    localparam int TT_W  = 8;
    localparam int LVL_W = 4;
    localparam int NLVL  = 1 << LVL_W;

    typedef struct packed {
        logic [TT_W-1:0] pend;
        logic            req;
        logic            chg;
    } irqsel_state_t;
endpackage

// File: rtl/irqsel_prio.sv
module irqsel_prio #(
    parameter int NLVL  = 16,
    parameter int LVL_W = 4
) (
    input  logic [NLVL-1:0]  req_i,
    output logic             found_o,
    output logic [LVL_W-1:0] lvl_o
);
    // Ascending scan; a later (higher) hit overwrites, so the top level wins.
    always_comb begin
        found_o = 1'b0;
        lvl_o   = '0;
        for (int i = 1; i < NLVL; i++) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                lvl_o   = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqsel_class.sv
module irqsel_class #(
    parameter int          TT_W  = 8,
    parameter int          LVL_W = 4,
    parameter logic [7:0]  BASE  = 8'h10
) (
    input  logic [TT_W-1:0] type_i,
    output logic            is_zero_o,
    output logic            is_ext_o
);
    localparam logic [TT_W-LVL_W-1:0] CLS = BASE[TT_W-1:LVL_W];

    always_comb begin
        is_zero_o = (type_i == '0);
        is_ext_o  = (type_i[TT_W-1:LVL_W] == CLS);
    end
endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
    import irqsel_pkg::*;
#(
    parameter logic [7:0] EXT_BASE = 8'h10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NLVL-1:0]  lvl_req_i,
    input  logic             take_clr_i,
    input  logic             sync_ld_i,
    input  logic [TT_W-1:0]  sync_type_i,
    output logic [TT_W-1:0]  pend_type_o,
    output logic             hard_req_o,
    output logic             chg_o
);
    irqsel_state_t st_d, st_q;

    logic             sel_found;
    logic [LVL_W-1:0] sel_lvl;
    logic             pend_zero;
    logic             pend_ext;
    logic [TT_W-1:0]  sel_type;

    irqsel_prio #(.NLVL(NLVL), .LVL_W(LVL_W)) u_prio (
        .req_i   (lvl_req_i),
        .found_o (sel_found),
        .lvl_o   (sel_lvl)
    );

    irqsel_class #(.TT_W(TT_W), .LVL_W(LVL_W), .BASE(EXT_BASE)) u_class (
        .type_i    (st_q.pend),
        .is_zero_o (pend_zero),
        .is_ext_o  (pend_ext)
    );

    assign sel_type = EXT_BASE | {{(TT_W-LVL_W){1'b0}}, sel_lvl};

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        if (take_clr_i) begin
            st_d.pend = '0;
            st_d.req  = 1'b0;
        end else if (sync_ld_i) begin
            st_d.pend = sync_type_i;
        end else if (|lvl_req_i) begin
            if ((pend_zero || pend_ext) && sel_found && (sel_type != st_q.pend)) begin
                st_d.pend = sel_type;
                st_d.req  = 1'b1;
                st_d.chg  = 1'b1;
            end
        end else if (pend_ext) begin
            st_d.pend = '0;
            st_d.req  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_type_o = st_q.pend;
    assign hard_req_o  = st_q.req;
    assign chg_o       = st_q.chg;
endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk #(
    parameter logic [7:0] EXT_BASE = 8'h10
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] lvl_req_i,
    input logic        take_clr_i,
    input logic        sync_ld_i,
    input logic [7:0]  pend_type_o,
    input logic        hard_req_o,
    input logic        chg_o
);
    logic quiet;
    logic ext_now;
    assign quiet   = !take_clr_i && !sync_ld_i;
    assign ext_now = (pend_type_o[7:4] == EXT_BASE[7:4]);

    a_r1_reset: assert property (@(posedge clk) rst |=> (pend_type_o == 8'h00 && !hard_req_o && !chg_o));

    a_r3_bit0_ignored: assert property (@(posedge clk) disable iff (rst)
        (quiet && lvl_req_i == 16'h0001) |=> ($stable(pend_type_o) && $stable(hard_req_o) && !chg_o));

    a_r5_blocked: assert property (@(posedge clk) disable iff (rst)
        (quiet && pend_type_o != 8'h00 && !ext_now) |=> ($stable(pend_type_o) && $stable(hard_req_o)));

    a_r6_pulse_means_change: assert property (@(posedge clk) disable iff (rst)
        chg_o |-> (hard_req_o && pend_type_o[7:4] == EXT_BASE[7:4] && pend_type_o[3:0] != 4'h0));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        chg_o |=> (!chg_o || $changed(pend_type_o)));

    a_r7_drop: assert property (@(posedge clk) disable iff (rst)
        (quiet && lvl_req_i == 16'h0000 && ext_now) |=> (pend_type_o == 8'h00 && !hard_req_o));

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        take_clr_i |=> (pend_type_o == 8'h00 && !hard_req_o && !chg_o));
endmodule

bind irqsel_top irqsel_chk #(.EXT_BASE(EXT_BASE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lvl_req_i   (lvl_req_i),
    .take_clr_i  (take_clr_i),
    .sync_ld_i   (sync_ld_i),
    .pend_type_o (pend_type_o),
    .hard_req_o  (hard_req_o),
    .chg_o       (chg_o)
);

// File: tb/irqsel_top_tb.sv
module irqsel_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] lvl = '0;
    logic        clr = 1'b0;
    logic        ld  = 1'b0;
    logic [7:0]  code = '0;
    logic [7:0]  pend;
    logic        req;
    logic        chg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_pend = '0;
    logic       m_req  = 1'b0;
    logic       m_chg  = 1'b0;
    string      m_tag  = "R1";

    always #2 clk = ~clk;

    irqsel_top u_dut (
        .clk(clk), .rst(rst), .lvl_req_i(lvl), .take_clr_i(clr),
        .sync_ld_i(ld), .sync_type_i(code),
        .pend_type_o(pend), .hard_req_o(req), .chg_o(chg)
    );

    function automatic logic [3:0] top_level(input logic [15:0] v);
        logic [3:0] r = 4'h0;
        for (int i = 15; i >= 1; i--) if (v[i]) begin r = 4'(i); break; end
        return r;
    endfunction

    task automatic model_step();
        logic [7:0] nt;
        logic       ext;
        ext   = (m_pend[7:4] == 4'h1);
        m_chg = 1'b0;
        if (rst) begin
            m_pend = '0; m_req = 0; m_tag = "R1";
        end else if (clr) begin
            m_pend = '0; m_req = 0; m_tag = "R8";
        end else if (ld) begin
            m_pend = code; m_tag = "R9";
        end else if (lvl == 16'h0001) begin
            m_tag = "R3";
        end else if (lvl != 0) begin
            if (m_pend != 0 && !ext) m_tag = "R5";
            else begin
                nt = 8'h10 | {4'h0, top_level(lvl)};
                if (nt != m_pend) begin
                    m_pend = nt; m_req = 1; m_chg = 1; m_tag = "R2";
                end else m_tag = "R6";
            end
        end else if (ext) begin
            m_pend = '0; m_req = 0; m_tag = "R7";
        end else m_tag = "R10";
    endtask

    task automatic check_outputs();
        checks++;
        if (pend !== m_pend || req !== m_req || chg !== m_chg) begin
            fails++;
            $display("FAIL %s: pend=%h req=%b chg=%b expected pend=%h req=%b chg=%b",
                     m_tag, pend, req, chg, m_pend, m_req, m_chg);
        end
    endtask

    // Drive at the falling edge, let the design capture at the rising edge,
    // compare at the next falling edge.
    task automatic cyc(input logic [15:0] v, input logic c, input logic l, input logic [7:0] t);
        @(negedge clk);
        lvl = v; clr = c; ld = l; code = t;
        model_step();
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        int seed;
        logic [15:0] v;
        seed = 1234;
        void'($urandom(seed));
        cyc(16'h0, 0, 0, 8'h0);                 // R1 reset state
        cyc(16'h0, 0, 0, 8'h0);
        rst = 1'b0;
        cyc(16'h0001, 0, 0, 8'h0);              // R3 bit 0 only
        cyc(16'h8421, 0, 0, 8'h0);              // R2 level 15 wins -> 0x1F
        cyc(16'h8000, 0, 0, 8'h0);              // R6 same type, no pulse
        cyc(16'h0024, 0, 0, 8'h0);              // R4 ext pending replaced -> 0x15
        cyc(16'h0000, 0, 0, 8'h0);              // R7 drop
        cyc(16'h0000, 0, 0, 8'h0);              // R10 idle
        cyc(16'h0010, 0, 1, 8'h09);             // R9 load beats selection
        cyc(16'hFFFE, 0, 0, 8'h0);              // R5 blocked
        cyc(16'h0000, 0, 0, 8'h0);              // R10 non-ext kept
        cyc(16'h0100, 1, 1, 8'h22);             // R8 clear beats load and level
        cyc(16'h0100, 0, 0, 8'h0);              // R2 -> 0x18
        cyc(16'h0002, 1, 0, 8'h0);              // R8 clear beats new level
        for (int n = 0; n < 3000; n++) begin
            case ($urandom_range(0, 4))
                0: v = 16'h0000;
                1: v = 16'h0001;
                2: v = 16'(1) << $urandom_range(0, 15);
                default: v = 16'($urandom);
            endcase
            cyc(v, ($urandom_range(0, 15) == 0), ($urandom_range(0, 9) == 0),
                ($urandom_range(0, 3) == 0) ? 8'h0 : 8'($urandom));
        end
        rst = 1'b1;
        cyc(16'hFFFF, 0, 0, 8'h0);              // R1 reset mid-run
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule